// File: doc/BRIEF.md
# Reservation Station Pool with Result Broadcast Wake-up

This block is a small pool of waiting slots that sits in front of one class of functional unit in an out-of-order core. The issue stage hands it one operation per cycle. Each source operand comes either as a value, or as the nonzero tag of the slot that will produce it. The pool places the operation in its lowest-numbered free slot. It reports the tag of that slot so that the renaming logic can record it. It raises a stall output when every slot is occupied.

Results come back on a single broadcast bus that carries a tag and a value. Every occupied slot compares both of its pending producer tags against the broadcast tag. Every slot that matches captures the value in that same cycle, however many slots were waiting on it. A slot whose operands are both present is offered to the functional unit through a valid/grant handshake, the oldest such slot first. A granted slot stays occupied but is never offered again. The slot is freed when its own tag appears on the broadcast bus.

Memory operations carry an offset. Their effective address, base operand plus offset, is computed inside the slot once the base operand is present. The slot is not offered before that address exists.

Top module: `rs_pool`

## Requirements
- R1: After reset all slots are free: `iss_stall` is 0, `fu_valid` is 0, and `iss_tag` equals `BASE_TAG`.
- R2: Slot k (index from 0) owns tag `BASE_TAG + k`, and `BASE_TAG` is at least 1. An accepted issue (`iss_valid` high, `iss_stall` low) fills the lowest-indexed free slot. `iss_tag` always shows the tag that the next accepted issue will receive.
- R3: `iss_stall` is 1 exactly when every slot is occupied. An issue presented while `iss_stall` is 1 is ignored and changes no slot.
- R4: An issued operand whose tag field is 0 is taken as present with the given value. A nonzero tag marks the operand as pending on the slot with that tag.
- R5: On a broadcast (`cdb_valid`), every occupied slot whose pending source tag equals `cdb_tag` stores `cdb_data` into that operand and marks it present, all in the same cycle.
- R6: If an operand is issued with a nonzero tag equal to `cdb_tag` in a cycle with `cdb_valid` high, it is stored as present with value `cdb_data`.
- R7: A slot is offered (`fu_valid` with its `fu_tag`, `fu_op`, `fu_vj`, `fu_vk`) only when both of its operands are present. Once `fu_grant` is high while it is offered, it is never offered again.
- R8: Among slots that may be offered, the one accepted earliest by issue is presented.
- R9: A broadcast whose `cdb_tag` equals an occupied slot's own tag frees that slot from the next cycle on.
- R10: For a memory operation (`iss_mem` = 1) the slot computes `fu_addr = Vj + iss_imm` (modulo 2^ADDR_W) one cycle after Vj becomes present. It is not offered before that address exists, and it is presented with `fu_mem` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code to hold |
| iss_mem | input | 1 | Operation is a memory access |
| iss_imm | input | DATA_W | Address offset for memory operations |
| iss_qj | input | TAG_W | Producer tag of first operand, 0 = present |
| iss_vj | input | DATA_W | First operand value (base for memory ops) |
| iss_qk | input | TAG_W | Producer tag of second operand, 0 = present |
| iss_vk | input | DATA_W | Second operand value |
| iss_stall | output | 1 | No free slot; issue is refused |
| iss_tag | output | TAG_W | Tag that the next accepted issue receives |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Tag of the broadcasting producer |
| cdb_data | input | DATA_W | Broadcast result value |
| fu_valid | output | 1 | A slot is offered to the functional unit |
| fu_grant | input | 1 | Functional unit takes the offered slot |
| fu_op | output | OP_W | Operation of the offered slot |
| fu_mem | output | 1 | Offered slot is a memory operation |
| fu_tag | output | TAG_W | Tag of the offered slot |
| fu_vj | output | DATA_W | First operand of the offered slot |
| fu_vk | output | DATA_W | Second operand of the offered slot |
| fu_addr | output | ADDR_W | Effective address of the offered slot |

## Verification
Issue, capture, grant and release all take effect at the clock edge that samples them. The offer outputs are driven only from slot state, so they show the new state right after that edge. A memory slot needs one more edge to form its address. The bench drives inputs and samples outputs at the falling edge. Each check is placed one edge after its stimulus, or two edges for memory addresses, and the bench also checks that a memory slot is not yet offered after the first edge. Age order is tested by refilling a freed low slot, so that index order and age order disagree.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_EXEC = 2'd2
  } slot_state_e;
endpackage

// File: rtl/rs_pool_alloc.sv
module rs_pool_alloc #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     busy,
  output logic             free_any,
  output logic [N-1:0]     alloc_oh,
  output logic [IDX_W-1:0] alloc_idx
);
  always_comb begin
    alloc_oh  = '0;
    alloc_idx = '0;
    free_any  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        alloc_oh  = '0;
        alloc_oh[i] = 1'b1;
        alloc_idx = IDX_W'(i);
        free_any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_pool_age.sv
module rs_pool_age #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         alloc_en,
  input  logic [N-1:0] alloc_oh,
  input  logic [N-1:0] ready,
  output logic [N-1:0] sel_oh,
  output logic         sel_any
);
  // older_q[i][j] = slot i was accepted before slot j
  logic [N-1:0][N-1:0] older_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      older_q <= '0;
    end else if (alloc_en) begin
      for (int n = 0; n < N; n++) begin
        if (alloc_oh[n]) begin
          for (int j = 0; j < N; j++) begin
            older_q[n][j] <= 1'b0;
            if (j != n) older_q[j][n] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      sel_oh[i] = ready[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && ready[j] && !older_q[i][j]) sel_oh[i] = 1'b0;
      end
    end
    sel_any = |ready;
  end
endmodule

// File: rtl/rs_pool_entry.sv
module rs_pool_entry
  import rs_pool_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 3,
  parameter logic [TAG_W-1:0] MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OP_W-1:0]   in_op,
  input  logic              in_mem,
  input  logic [DATA_W-1:0] in_imm,
  input  logic [TAG_W-1:0]  in_qj,
  input  logic [DATA_W-1:0] in_vj,
  input  logic [TAG_W-1:0]  in_qk,
  input  logic [DATA_W-1:0] in_vk,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic              take,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic              mem,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk,
  output logic [TAG_W-1:0]  qj,
  output logic [TAG_W-1:0]  qk,
  output logic [ADDR_W-1:0] addr
);
  slot_state_e      state_q;
  logic [DATA_W-1:0] imm_q;
  logic              addr_ok_q;
  logic              hit_in_j, hit_in_k, hit_j, hit_k, own_hit;

  assign hit_in_j = bc_valid && (in_qj != '0) && (in_qj == bc_tag);
  assign hit_in_k = bc_valid && (in_qk != '0) && (in_qk == bc_tag);
  assign hit_j    = bc_valid && (qj != '0) && (qj == bc_tag);
  assign hit_k    = bc_valid && (qk != '0) && (qk == bc_tag);
  assign own_hit  = bc_valid && (bc_tag == MY_TAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SLOT_FREE;
      qj        <= '0;
      qk        <= '0;
      vj        <= '0;
      vk        <= '0;
      op        <= '0;
      mem       <= 1'b0;
      imm_q     <= '0;
      addr      <= '0;
      addr_ok_q <= 1'b0;
    end else if (wr_en) begin
      state_q   <= SLOT_WAIT;
      op        <= in_op;
      mem       <= in_mem;
      imm_q     <= in_imm;
      addr_ok_q <= 1'b0;
      vj        <= hit_in_j ? bc_data : in_vj;
      qj        <= hit_in_j ? '0 : in_qj;
      vk        <= hit_in_k ? bc_data : in_vk;
      qk        <= hit_in_k ? '0 : in_qk;
    end else if (state_q != SLOT_FREE) begin
      if (own_hit) begin
        state_q <= SLOT_FREE;
      end else begin
        if (hit_j) begin
          vj <= bc_data;
          qj <= '0;
        end
        if (hit_k) begin
          vk <= bc_data;
          qk <= '0;
        end
        if (take) state_q <= SLOT_EXEC;
        if (mem && !addr_ok_q && qj == '0) begin
          addr      <= ADDR_W'(vj + imm_q);
          addr_ok_q <= 1'b1;
        end
      end
    end
  end

  assign busy  = (state_q != SLOT_FREE);
  assign ready = (state_q == SLOT_WAIT) && (qj == '0) && (qk == '0) &&
                 (!mem || addr_ok_q);
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int NUM_RS   = 4,
  parameter int TOTAL_RS = 7,
  parameter int BASE_TAG = 1,
  parameter int OP_W     = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  parameter int TAG_W    = $clog2(TOTAL_RS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic              iss_mem,
  input  logic [DATA_W-1:0] iss_imm,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qk,
  input  logic [DATA_W-1:0] iss_vk,
  output logic              iss_stall,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              fu_valid,
  input  logic              fu_grant,
  output logic [OP_W-1:0]   fu_op,
  output logic              fu_mem,
  output logic [TAG_W-1:0]  fu_tag,
  output logic [DATA_W-1:0] fu_vj,
  output logic [DATA_W-1:0] fu_vk,
  output logic [ADDR_W-1:0] fu_addr
);
  localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

  logic [NUM_RS-1:0]             busy_vec, ready_vec, alloc_oh, sel_oh, wr_vec, take_vec;
  logic [NUM_RS-1:0][TAG_W-1:0]  qj_vec, qk_vec;
  logic [NUM_RS-1:0][OP_W-1:0]   op_vec;
  logic [NUM_RS-1:0][DATA_W-1:0] vj_vec, vk_vec;
  logic [NUM_RS-1:0][ADDR_W-1:0] addr_vec;
  logic [NUM_RS-1:0]             mem_vec;
  logic [IDX_W-1:0]              alloc_idx;
  logic                          free_any, accept, sel_any;

  rs_pool_alloc #(.N(NUM_RS)) u_alloc (
    .busy(busy_vec), .free_any(free_any), .alloc_oh(alloc_oh), .alloc_idx(alloc_idx)
  );

  assign accept    = iss_valid && free_any;
  assign iss_stall = !free_any;
  assign iss_tag   = TAG_W'(BASE_TAG) + TAG_W'(alloc_idx);
  assign wr_vec    = alloc_oh & {NUM_RS{accept}};

  rs_pool_age #(.N(NUM_RS)) u_age (
    .clk(clk), .rst(rst), .alloc_en(accept), .alloc_oh(alloc_oh),
    .ready(ready_vec), .sel_oh(sel_oh), .sel_any(sel_any)
  );

  assign take_vec = sel_oh & {NUM_RS{fu_grant}};

  for (genvar g = 0; g < NUM_RS; g++) begin : g_slot
    rs_pool_entry #(
      .OP_W(OP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W),
      .MY_TAG(TAG_W'(BASE_TAG + g))
    ) u_slot (
      .clk(clk), .rst(rst), .wr_en(wr_vec[g]),
      .in_op(iss_op), .in_mem(iss_mem), .in_imm(iss_imm),
      .in_qj(iss_qj), .in_vj(iss_vj), .in_qk(iss_qk), .in_vk(iss_vk),
      .bc_valid(cdb_valid), .bc_tag(cdb_tag), .bc_data(cdb_data),
      .take(take_vec[g]), .busy(busy_vec[g]), .ready(ready_vec[g]),
      .op(op_vec[g]), .mem(mem_vec[g]), .vj(vj_vec[g]), .vk(vk_vec[g]),
      .qj(qj_vec[g]), .qk(qk_vec[g]), .addr(addr_vec[g])
    );
  end

  always_comb begin
    fu_op   = '0;
    fu_mem  = 1'b0;
    fu_tag  = '0;
    fu_vj   = '0;
    fu_vk   = '0;
    fu_addr = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (sel_oh[i]) begin
        fu_op   = fu_op   | op_vec[i];
        fu_mem  = fu_mem  | mem_vec[i];
        fu_tag  = fu_tag  | TAG_W'(BASE_TAG + i);
        fu_vj   = fu_vj   | vj_vec[i];
        fu_vk   = fu_vk   | vk_vec[i];
        fu_addr = fu_addr | addr_vec[i];
      end
    end
  end
  assign fu_valid = sel_any;
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int N        = 4,
  parameter int TAG_W    = 3,
  parameter int BASE_TAG = 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     iss_valid,
  input logic                     iss_stall,
  input logic                     cdb_valid,
  input logic [TAG_W-1:0]         cdb_tag,
  input logic                     fu_valid,
  input logic                     fu_grant,
  input logic [TAG_W-1:0]         fu_tag,
  input logic [N-1:0]             busy,
  input logic [N-1:0][TAG_W-1:0]  qj,
  input logic [N-1:0][TAG_W-1:0]  qk
);
  AST_ONE_FILL_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(busy) <= $past($countones(busy)) + 1)); // R2

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_stall && !cdb_valid) |=> iss_stall); // R3

  AST_NO_REOFFER: assert property (@(posedge clk) disable iff (rst)
    (fu_valid && fu_grant) |=> !(fu_valid && fu_tag == $past(fu_tag))); // R7

  for (genvar g = 0; g < N; g++) begin : g_chk
    AST_CAPTURE_J: assert property (@(posedge clk) disable iff (rst)
      (cdb_valid && busy[g] && qj[g] != '0 && qj[g] == cdb_tag) |=> (qj[g] == '0 || !busy[g])); // R5
    AST_CAPTURE_K: assert property (@(posedge clk) disable iff (rst)
      (cdb_valid && busy[g] && qk[g] != '0 && qk[g] == cdb_tag) |=> (qk[g] == '0 || !busy[g])); // R5
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (cdb_valid && busy[g] && cdb_tag == TAG_W'(BASE_TAG + g)) |=> !busy[g]); // R9
  end
endmodule

bind rs_pool rs_pool_chk #(.N(NUM_RS), .TAG_W(TAG_W), .BASE_TAG(BASE_TAG)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_stall(iss_stall),
  .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .fu_valid(fu_valid),
  .fu_grant(fu_grant), .fu_tag(fu_tag), .busy(busy_vec), .qj(qj_vec), .qk(qk_vec)
);

// File: tb/test_rs_pool.sv
module test_rs_pool;
  logic        clk = 1'b0;
  logic        rst;
  logic        iss_valid, iss_mem, cdb_valid, fu_grant;
  logic [3:0]  iss_op;
  logic [15:0] iss_imm, iss_vj, iss_vk, cdb_data;
  logic [2:0]  iss_qj, iss_qk, cdb_tag;
  logic        iss_stall, fu_valid, fu_mem;
  logic [2:0]  iss_tag, fu_tag;
  logic [3:0]  fu_op;
  logic [15:0] fu_vj, fu_vk, fu_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rs_pool i_rs_pool (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op), .iss_mem(iss_mem),
    .iss_imm(iss_imm), .iss_qj(iss_qj), .iss_vj(iss_vj), .iss_qk(iss_qk), .iss_vk(iss_vk),
    .iss_stall(iss_stall), .iss_tag(iss_tag), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_data(cdb_data), .fu_valid(fu_valid), .fu_grant(fu_grant), .fu_op(fu_op),
    .fu_mem(fu_mem), .fu_tag(fu_tag), .fu_vj(fu_vj), .fu_vk(fu_vk), .fu_addr(fu_addr)
  );

  localparam logic [3:0]  T_OP [4] = '{4'h1, 4'h7, 4'hA, 4'hF};
  localparam logic [15:0] T_VJ [4] = '{16'h0001, 16'hFFFF, 16'h1234, 16'h8000};
  localparam logic [15:0] T_VK [4] = '{16'h0002, 16'h0000, 16'hABCD, 16'h7FFF};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic [3:0] op, input logic mem, input logic [15:0] imm,
                     input logic [2:0] qj, input logic [15:0] vj,
                     input logic [2:0] qk, input logic [15:0] vk);
    iss_valid = 1'b1; iss_op = op; iss_mem = mem; iss_imm = imm;
    iss_qj = qj; iss_vj = vj; iss_qk = qk; iss_vk = vk;
  endtask

  task automatic issue(input logic [3:0] op, input logic mem, input logic [15:0] imm,
                       input logic [2:0] qj, input logic [15:0] vj,
                       input logic [2:0] qk, input logic [15:0] vk);
    put(op, mem, imm, qj, vj, qk, vk);
    step();
    iss_valid = 1'b0;
  endtask

  task automatic bcast(input logic [2:0] tag, input logic [15:0] data);
    cdb_valid = 1'b1; cdb_tag = tag; cdb_data = data;
    step();
    cdb_valid = 1'b0;
  endtask

  task automatic grant();
    fu_grant = 1'b1;
    step();
    fu_grant = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; iss_valid = 1'b0; iss_mem = 1'b0; iss_op = '0; iss_imm = '0;
    iss_qj = '0; iss_qk = '0; iss_vj = '0; iss_vk = '0;
    cdb_valid = 1'b0; cdb_tag = '0; cdb_data = '0; fu_grant = 1'b0;
    @(negedge clk); step(); step();
    rst = 1'b0;
    step();

    // R1 reset state
    chk("R1 stall", 32'(iss_stall), 0);
    chk("R1 fu_valid", 32'(fu_valid), 0);
    chk("R1 iss_tag", 32'(iss_tag), 1);

    // Vector table: ready operands go straight to the unit (R4, R7, R9)
    for (int i = 0; i < 4; i++) begin
      issue(T_OP[i], 1'b0, 16'h0, 3'd0, T_VJ[i], 3'd0, T_VK[i]);
      chk("R4 valid", 32'(fu_valid), 1);
      chk("R4 op", 32'(fu_op), 32'(T_OP[i]));
      chk("R4 vj", 32'(fu_vj), 32'(T_VJ[i]));
      chk("R4 vk", 32'(fu_vk), 32'(T_VK[i]));
      chk("R2 tag slot0", 32'(fu_tag), 1);
      grant();
      chk("R7 not reoffered", 32'(fu_valid), 0);
      bcast(3'd1, 16'h0);
      chk("R9 slot0 free", 32'(iss_tag), 1);
    end

    // Dependency chain: two waiters on tag 1
    issue(4'h2, 1'b0, 16'h0, 3'd0, 16'h0010, 3'd0, 16'h0020);
    chk("R2 next tag", 32'(iss_tag), 2);
    issue(4'h3, 1'b0, 16'h0, 3'd1, 16'h0000, 3'd0, 16'h0005);
    issue(4'h4, 1'b0, 16'h0, 3'd0, 16'h0007, 3'd1, 16'h0000);
    chk("R7 only ready slot", 32'(fu_tag), 1);
    grant();
    chk("R7 waiters held", 32'(fu_valid), 0);
    bcast(3'd1, 16'h0099);
    chk("R5 first waiter offered", 32'(fu_tag), 2);
    chk("R5 first waiter vj", 32'(fu_vj), 16'h0099);
    chk("R5 first waiter vk", 32'(fu_vk), 16'h0005);
    chk("R9 released slot0", 32'(iss_tag), 1);
    grant();
    chk("R5 second waiter", 32'(fu_tag), 3);
    chk("R5 second waiter vj", 32'(fu_vj), 16'h0007);
    chk("R5 second waiter vk", 32'(fu_vk), 16'h0099);
    bcast(3'd2, 16'h0);
    bcast(3'd3, 16'h0);
    chk("R9 all free", 32'(iss_stall), 0);

    // Fill, stall, ignore, then age order differing from index order
    for (int i = 0; i < 4; i++) begin
      chk("R2 tag seq", 32'(iss_tag), 32'(i + 1));
      issue(4'h5, 1'b0, 16'h0, 3'd7, 16'h0000, 3'd0, 16'h0001);
    end
    chk("R3 stall full", 32'(iss_stall), 1);
    issue(4'h6, 1'b0, 16'h0, 3'd0, 16'h0BAD, 3'd0, 16'h0BAD);
    chk("R3 issue ignored", 32'(fu_valid), 0);
    chk("R3 still full", 32'(iss_stall), 1);
    bcast(3'd1, 16'h0);
    chk("R9 stall clears", 32'(iss_stall), 0);
    chk("R2 lowest free", 32'(iss_tag), 1);
    issue(4'h8, 1'b0, 16'h0, 3'd0, 16'h0033, 3'd0, 16'h0044);
    chk("R8 lone ready", 32'(fu_tag), 1);
    bcast(3'd7, 16'h0011);
    chk("R8 oldest first", 32'(fu_tag), 2);
    chk("R5 shared capture", 32'(fu_vj), 16'h0011);
    grant();
    chk("R8 second oldest", 32'(fu_tag), 3);
    chk("R5 shared capture 3", 32'(fu_vj), 16'h0011);
    grant();
    chk("R8 third oldest", 32'(fu_tag), 4);
    grant();
    chk("R8 youngest last", 32'(fu_tag), 1);
    chk("R8 youngest vj", 32'(fu_vj), 16'h0033);
    grant();
    chk("R7 none left", 32'(fu_valid), 0);
    for (int t = 1; t <= 4; t++) bcast(3'(t), 16'h0);

    // R6 same-cycle broadcast at issue
    put(4'h9, 1'b0, 16'h0, 3'd6, 16'h0000, 3'd0, 16'h0003);
    cdb_valid = 1'b1; cdb_tag = 3'd6; cdb_data = 16'h0055;
    step();
    iss_valid = 1'b0; cdb_valid = 1'b0;
    chk("R6 bypass ready", 32'(fu_valid), 1);
    chk("R6 bypass value", 32'(fu_vj), 16'h0055);
    bcast(3'd1, 16'h0);

    // R10 memory operations
    issue(4'hC, 1'b1, 16'h0020, 3'd0, 16'h0100, 3'd0, 16'h0000);
    chk("R10 not before address", 32'(fu_valid), 0);
    step();
    chk("R10 offered", 32'(fu_valid), 1);
    chk("R10 address", 32'(fu_addr), 16'h0120);
    chk("R10 mem flag", 32'(fu_mem), 1);
    bcast(3'd1, 16'h0);
    issue(4'hD, 1'b1, 16'h0004, 3'd5, 16'h0000, 3'd0, 16'h0000);
    chk("R10 waits base", 32'(fu_valid), 0);
    bcast(3'd5, 16'h0200);
    chk("R10 base just captured", 32'(fu_valid), 0);
    step();
    chk("R10 late address", 32'(fu_addr), 16'h0204);
    chk("R10 late offered", 32'(fu_valid), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule